// File: doc/BRIEF.md
# I2C Host with Header-Sized Reads

This block is an I2C bus controller for a single target device. It turns a system clock into SCL and SDA waveforms through two open-drain pull-down enables, and it reads back the wire levels. A read request fetches one variable-length message from the target. The first byte that arrives holds the message length, counting itself. The host acknowledges every byte up to the last one, NACKs that last byte and then issues Stop. A write request sends a run of command bytes, which a user side supplies one at a time, and closes with Stop.

Received bytes come out as a one-cycle strobe, together with the byte value and a last-byte flag. The phase length comes from an input in system clock cycles. The target may hold SCL low to slow the transfer, and every new high phase waits until the line is actually high. An address or data byte that gets no acknowledge ends the transfer with Stop and an error pulse.

Top module: `i2cMsgHost`

## Requirements
- R1: After reset, and whenever `busy` is low, both `sclOe` and `sdaOe` are low (both lines released).
- R2: A transfer begins with exactly one Start: `sdaOe` rises while SCL is high, and SCL is pulled low only `halfPeriod` cycles later. It ends with exactly one Stop: SDA is released while SCL is high, after `sdaOe` was driven low during the final SCL low phase.
- R3: The first frame carries `targetAddr` MSB first, followed by a direction bit: 1 for a read, 0 for a write.
- R4: Outside Start and Stop, SDA changes only while SCL is low. Bits are sampled when SCL reads high.
- R5: After releasing SCL, the host does not start the high phase until `sclIn` reads high. A target that holds SCL low lengthens the low phase and corrupts no bit.
- R6: If the address byte is not acknowledged, the host issues Stop and pulses `nackErr` together with `done`. No data byte is moved.
- R7: On a read, the first received byte S sets the message length max(S,1). Exactly that many bytes are read. Each byte except the last gets ACK (SDA low on the ninth clock). The last byte gets NACK (SDA released), followed at once by Stop.
- R8: A size byte of 0 or 1 gives a one-byte read. That byte is NACKed and stopped.
- R9: On a write, each byte is taken from `cmdByte` with a one-cycle `cmdTake` pulse and sent MSB first. After the byte flagged by `cmdLast` is acknowledged, Stop follows. `cmdByte` must be valid when the request is made.
- R10: If the target does not acknowledge a written byte, the host issues Stop at once and pulses `nackErr` with `done`. No further byte is taken.
- R11: Each received byte appears on `rxData` with a one-cycle `rxValid`, assembled MSB first. `rxLast` is high with the final byte only.
- R12: Requests are ignored while `busy` is high. When `readReq` and `writeReq` arrive together, the read wins.
- R13: Without stretching, every SCL low phase and every SCL high phase between clocks lasts `halfPeriod` cycles. The host pulls SCL low only after it has read the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfPeriod | input | DIV_W | SCL phase length in clock cycles (at least 2) |
| targetAddr | input | 7 | 7-bit target address |
| readReq | input | 1 | Start a message read (one-cycle pulse) |
| writeReq | input | 1 | Start a command write (one-cycle pulse) |
| cmdByte | input | 8 | Next command byte to send |
| cmdLast | input | 1 | `cmdByte` is the final command byte |
| cmdTake | output | 1 | Pulse: `cmdByte` was consumed |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Pulse: `rxData` holds a new byte |
| rxLast | output | 1 | Received byte is the last of the message |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: transfer finished, bus free |
| nackErr | output | 1 | Pulse with `done`: the transfer ended on a missing acknowledge |
| sclIn | input | 1 | Level read back from SCL |
| sdaIn | input | 1 | Level read back from SDA |
| sclOe | output | 1 | Pull SCL low |
| sdaOe | output | 1 | Pull SDA low |

## Verification
Two functions can fall on the same ninth clock. One is the host's own ACK/NACK decision for a read byte. The other is the length parse from the size byte, which is captured on the rising edge of the eighth bit just before that decision. With a size of 0, 1 or 2, the first byte is both the length carrier and the last or next-to-last byte, so the NACK must already reflect a length that is one cycle old. The bench sweeps sizes 0 through 5 at two phase lengths. Its target model records the level the host leaves on SDA at every ninth rising edge and compares it with the arithmetic pattern "low unless index equals max(S,1)-1". It also checks that Stop is the very next bus event.

// File: rtl/i2cHostPkg.sv
package i2cHostPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LOW, ST_RISE, ST_HIGH,
    ST_STOP_LOW, ST_STOP_RISE, ST_STOP_HIGH, ST_FREE
  } hostState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadCmd;
    logic setSda;
    logic forceLow;
    logic releaseSda;
    logic sample;
    logic nextBit;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic atAck;
    logic ackOk;
    logic isRead;
    logic addrPhase;
    logic lastRx;
    logic lastCmd;
  } status_t;
endpackage

// File: rtl/i2cHostCtrl.sv
module i2cHostCtrl
  import i2cHostPkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             readReq,
  input  logic             writeReq,
  input  logic             sclIn,
  input  status_t          stat,
  output strobe_t          strb,
  output hostState_e       state,
  output logic             sclOe,
  output logic             busy,
  output logic             done,
  output logic             nackErr
);
  hostState_e nxt;
  logic [DIV_W-1:0] tmr;
  logic tmrDone, errFlag, errSet;

  assign tmrDone = (tmr == halfPeriod - 1'b1);

  always_comb begin
    strb   = '0;
    nxt    = state;
    errSet = 1'b0;
    unique case (state)
      ST_IDLE: if (readReq || writeReq) begin
        strb.loadAddr = 1'b1;
        strb.setSda   = 1'b1;
        strb.forceLow = 1'b1;
        nxt = ST_START;
      end
      ST_START: if (tmrDone) nxt = ST_LOW;
      ST_LOW: begin
        if (tmr == '0) strb.setSda = 1'b1;
        if (tmrDone) nxt = ST_RISE;
      end
      ST_RISE: if (sclIn) begin
        strb.sample = 1'b1;
        nxt = ST_HIGH;
      end
      ST_HIGH: if (tmrDone) begin
        if (!stat.atAck) begin
          strb.nextBit = 1'b1;
          nxt = ST_LOW;
        end else if ((stat.addrPhase || !stat.isRead) && !stat.ackOk) begin
          errSet = 1'b1;
          nxt = ST_STOP_LOW;
        end else if (stat.addrPhase) begin
          strb.nextBit = 1'b1;
          strb.loadCmd = !stat.isRead;
          nxt = ST_LOW;
        end else if (!stat.isRead) begin
          if (stat.lastCmd) nxt = ST_STOP_LOW;
          else begin
            strb.nextBit = 1'b1;
            strb.loadCmd = 1'b1;
            nxt = ST_LOW;
          end
        end else begin
          if (stat.lastRx) nxt = ST_STOP_LOW;
          else begin
            strb.nextBit = 1'b1;
            nxt = ST_LOW;
          end
        end
      end
      ST_STOP_LOW: begin
        if (tmr == '0) begin
          strb.setSda   = 1'b1;
          strb.forceLow = 1'b1;
        end
        if (tmrDone) nxt = ST_STOP_RISE;
      end
      ST_STOP_RISE: if (sclIn) nxt = ST_STOP_HIGH;
      ST_STOP_HIGH: if (tmrDone) begin
        strb.releaseSda = 1'b1;
        nxt = ST_FREE;
      end
      ST_FREE: if (tmrDone) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      errFlag <= 1'b0;
      done    <= 1'b0;
      nackErr <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) tmr <= (nxt == ST_HIGH) ? DIV_W'(1) : '0;
      else              tmr <= tmr + 1'b1;
      if (strb.loadAddr) errFlag <= 1'b0;
      else if (errSet)   errFlag <= 1'b1;
      done    <= (state == ST_FREE) && tmrDone;
      nackErr <= (state == ST_FREE) && tmrDone && errFlag;
    end
  end

  assign sclOe = (state == ST_LOW) || (state == ST_STOP_LOW);
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/i2cHostData.sv
module i2cHostData
  import i2cHostPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              readReq,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              cmdLast,
  output status_t           stat,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxLast,
  output logic              cmdTake
);
  localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shiftReg, rxCount, msgLen, byteNow, effLen;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic isRead, addrPhase, ackBit, lastRx, lastCmd, txMode, driveBit, isLast;

  assign txMode  = addrPhase || !isRead;
  assign byteNow = {shiftReg[BYTE_W-2:0], sdaIn};
  assign effLen  = (rxCount != '0) ? msgLen : ((byteNow <= 1) ? BYTE_W'(1) : byteNow);
  assign isLast  = ({1'b0, rxCount} + 1'b1) >= {1'b0, effLen};

  always_comb begin
    if (bitCnt == ACK_SLOT) driveBit = txMode ? 1'b0 : !lastRx;
    else                    driveBit = txMode ? !shiftReg[BYTE_W-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0; bitCnt <= '0; isRead <= 1'b0; addrPhase <= 1'b0;
      ackBit <= 1'b1; rxCount <= '0; msgLen <= '0; lastRx <= 1'b0;
      lastCmd <= 1'b0; sdaOe <= 1'b0; rxData <= '0; rxValid <= 1'b0;
      rxLast <= 1'b0; cmdTake <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      rxLast  <= 1'b0;
      cmdTake <= 1'b0;
      if (strb.loadAddr) begin
        shiftReg  <= {targetAddr, readReq};
        bitCnt    <= '0;
        isRead    <= readReq;
        addrPhase <= 1'b1;
        rxCount   <= '0;
        lastRx    <= 1'b0;
        lastCmd   <= 1'b0;
      end
      if (strb.setSda)     sdaOe <= strb.forceLow || driveBit;
      if (strb.releaseSda) sdaOe <= 1'b0;
      if (strb.sample) begin
        if (bitCnt == ACK_SLOT) ackBit <= sdaIn;
        else if (!txMode) begin
          shiftReg <= byteNow;
          if (bitCnt == LAST_BIT) begin
            rxData  <= byteNow;
            rxValid <= 1'b1;
            rxLast  <= isLast;
            lastRx  <= isLast;
            rxCount <= rxCount + 1'b1;
            if (rxCount == '0) msgLen <= effLen;
          end
        end
      end
      if (strb.nextBit) begin
        if (bitCnt == ACK_SLOT) begin
          bitCnt    <= '0;
          addrPhase <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
          if (txMode) shiftReg <= shiftReg << 1;
        end
      end
      if (strb.loadCmd) begin
        shiftReg <= cmdByte;
        lastCmd  <= cmdLast;
        cmdTake  <= 1'b1;
      end
    end
  end

  assign stat.atAck     = (bitCnt == ACK_SLOT);
  assign stat.ackOk     = !ackBit;
  assign stat.isRead    = isRead;
  assign stat.addrPhase = addrPhase;
  assign stat.lastRx    = lastRx;
  assign stat.lastCmd   = lastCmd;
endmodule

// File: rtl/i2cMsgHost.sv
module i2cMsgHost
  import i2cHostPkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  halfPeriod,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              readReq,
  input  logic              writeReq,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              cmdLast,
  output logic              cmdTake,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxLast,
  output logic              busy,
  output logic              done,
  output logic              nackErr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe
);
  strobe_t    strb;
  status_t    stat;
  hostState_e hostState;

  i2cHostCtrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .halfPeriod(halfPeriod), .readReq(readReq),
    .writeReq(writeReq), .sclIn(sclIn), .stat(stat), .strb(strb),
    .state(hostState), .sclOe(sclOe), .busy(busy), .done(done), .nackErr(nackErr)
  );

  i2cHostData uData (
    .clk(clk), .rstN(rstN), .strb(strb), .targetAddr(targetAddr),
    .readReq(readReq), .sdaIn(sdaIn), .cmdByte(cmdByte), .cmdLast(cmdLast),
    .stat(stat), .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid),
    .rxLast(rxLast), .cmdTake(cmdTake)
  );
endmodule

// File: rtl/i2cMsgHostChk.sv
module i2cMsgHostChk
  import i2cHostPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       sclIn,
  input logic       busy,
  input logic       done,
  input logic       nackErr,
  input logic       cmdTake,
  input hostState_e hostState
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  // R4
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !sclOe && $past(!sclOe)) |->
      ((hostState == ST_START && $rose(sdaOe)) || (hostState == ST_FREE && $fell(sdaOe))));

  // R5
  stretch_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostState == ST_RISE && !sclIn) |=> (hostState == ST_RISE));

  // R6
  nack_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    nackErr |-> done);

  // R13
  pull_after_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> $past(sclIn));

  // R9
  take_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdTake |=> !cmdTake);
endmodule

bind i2cMsgHost i2cMsgHostChk uChk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .sclIn(sclIn),
  .busy(busy), .done(done), .nackErr(nackErr), .cmdTake(cmdTake),
  .hostState(hostState)
);

// File: tb/i2cMsgHost_test.sv
module i2cMsgHost_test;
  localparam logic [6:0] TGT = 7'h52;
  localparam int STRK = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hp = 16'd3;
  logic [6:0] addr = TGT;
  logic readReq = 1'b0, writeReq = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic cmdLast = 1'b0;
  logic cmdTake, rxValid, rxLast, busy, done, nackErr, sclOe, sdaOe;
  logic [7:0] rxData;
  logic stretch = 1'b0, tgtLow = 1'b0;
  wire sclIn = !(sclOe || stretch);
  wire sdaIn = !(sdaOe || tgtLow);

  always #5 clk = !clk;

  i2cMsgHost uut (
    .clk(clk), .rstN(rstN), .halfPeriod(hp), .targetAddr(addr),
    .readReq(readReq), .writeReq(writeReq), .cmdByte(cmdByte), .cmdLast(cmdLast),
    .cmdTake(cmdTake), .rxData(rxData), .rxValid(rxValid), .rxLast(rxLast),
    .busy(busy), .done(done), .nackErr(nackErr), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  int nChecks = 0, nFails = 0;
  // target model state
  logic [7:0] rdBytes [8];
  logic [7:0] wrData [4];
  logic [7:0] wrSeen [8];
  logic [7:0] shiftIn, addrSeen;
  logic prevScl = 1'b1, prevSda = 1'b1;
  int bitPos, byteIdx, wrCnt, nWr, nackAt, expN, rxIdx, rxErr, ackErr;
  int startCnt, stopCnt, timErr, lowCnt, highCnt, fallCnt, stretchAt, stretchLeft;
  int cmdIdx, takes, lastStretchLow;
  bit inAddr, fresh, rwSeen, addrAcked, rdDone, startHigh, skipHigh, stretchedLow;
  bit gotDone, gotErr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearModel();
    startCnt = 0; stopCnt = 0; timErr = 0; fallCnt = 0; byteIdx = 0; wrCnt = 0;
    rxIdx = 0; rxErr = 0; ackErr = 0; takes = 0; cmdIdx = 0; addrSeen = 8'hxx;
    lastStretchLow = 0; addrAcked = 0; rwSeen = 0; rdDone = 0;
  endtask

  // bus target, stretch source, user-side monitor; all at the falling clock edge
  initial begin
    bitPos = 0; inAddr = 0; fresh = 0; startHigh = 1; skipHigh = 0; stretchedLow = 0;
    lowCnt = 0; highCnt = 0; stretchLeft = 0; stretchAt = -1; nWr = 1; nackAt = 0; expN = 0;
    clearModel();
    forever begin
      @(negedge clk);
      begin
        automatic logic sB = sclIn;
        automatic logic dB = sdaIn;
        if (stretchLeft > 0) begin
          stretchLeft--;
          if (stretchLeft == 0) stretch = 1'b0;
        end
        if (sB && prevScl && prevSda && !dB) begin
          startCnt++; bitPos = 0; inAddr = 1; fresh = 1; addrAcked = 0; rdDone = 0;
          startHigh = 1;
        end
        if (sB && prevScl && !prevSda && dB) stopCnt++;
        if (sB && !prevScl) begin
          if (stretchedLow) begin lastStretchLow = lowCnt; stretchedLow = 0; end
          else if (lowCnt != hp) timErr++;
          highCnt = 0;
          if (bitPos < 8) shiftIn = {shiftIn[6:0], dB};
          else if (!inAddr && rwSeen && addrAcked) begin
            if (dB != (byteIdx == expN - 1)) ackErr++;
            if (dB) rdDone = 1;
            byteIdx++;
          end
        end
        if (!sB && prevScl) begin
          if (!startHigh && !skipHigh && highCnt != hp) timErr++;
          startHigh = 0; skipHigh = 0; lowCnt = 0; fallCnt++;
          if (fallCnt == stretchAt) begin
            stretch = 1'b1; stretchLeft = STRK; stretchedLow = 1; skipHigh = 1;
          end
          if (fresh) fresh = 0;
          else if (bitPos == 8) begin bitPos = 0; inAddr = 0; end
          else bitPos++;
          tgtLow = 1'b0;
          if (bitPos == 8 && inAddr) begin
            addrSeen = shiftIn; rwSeen = shiftIn[0];
            addrAcked = (shiftIn[7:1] == TGT); tgtLow = addrAcked;
          end else if (bitPos == 8 && !rwSeen && addrAcked) begin
            if (wrCnt < 8) wrSeen[wrCnt] = shiftIn;
            wrCnt++; tgtLow = (wrCnt != nackAt);
          end else if (bitPos < 8 && !inAddr && rwSeen && addrAcked && !rdDone)
            tgtLow = !rdBytes[byteIdx % 8][7 - bitPos];
        end
        if (sB) highCnt++; else lowCnt++;
        prevScl = sB; prevSda = dB;
      end
      if (rxValid) begin
        if (rxData != rdBytes[rxIdx % 8] || rxLast != (rxIdx == expN - 1)) rxErr++;
        rxIdx++;
      end
      if (cmdTake) begin
        takes++; cmdIdx++;
        cmdByte = wrData[cmdIdx % 4];
        cmdLast = (cmdIdx == nWr - 1);
      end
    end
  end

  task automatic waitDone();
    gotDone = 0; gotErr = 0;
    for (int i = 0; i < 20000 && !gotDone; i++) begin
      @(negedge clk);
      if (done) begin gotDone = 1; gotErr = nackErr; end
    end
    chk(gotDone, "R2 transfer completes", gotDone, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseReq(input bit rd, input bit wr);
    @(negedge clk);
    readReq = rd; writeReq = wr;
    @(negedge clk);
    readReq = 1'b0; writeReq = 1'b0;
  endtask

  task automatic runRead(input logic [7:0] size, input bit good, input int stAt);
    clearModel();
    addr = good ? TGT : TGT ^ 7'h11;
    expN = good ? ((size <= 1) ? 1 : size) : 0;
    rdBytes[0] = size;
    for (int i = 1; i < 8; i++) rdBytes[i] = 8'(8'h3C + i * 8'd37 + size);
    stretchAt = stAt;
    pulseReq(1'b1, 1'b0);
    waitDone();
    chk(addrSeen == {addr, 1'b1}, "R3 read address frame", addrSeen, {addr, 1'b1});
    chk(startCnt == 1 && stopCnt == 1, "R2 one Start one Stop", startCnt * 10 + stopCnt, 11);
    chk(timErr == 0, "R13 phase lengths", timErr, 0);
    chk(!busy && !sclOe && !sdaOe, "R1 released after read", {busy, sclOe, sdaOe}, 0);
    if (good) begin
      chk(rxIdx == expN, (size <= 1) ? "R8 single byte count" : "R7 byte count", rxIdx, expN);
      chk(byteIdx == expN && ackErr == 0, "R7 ACK/NACK pattern", ackErr, 0);
      chk(rxErr == 0, "R11 received stream", rxErr, 0);
      chk(!gotErr, "R7 no error flag", gotErr, 0);
    end else begin
      chk(gotErr && rxIdx == 0, "R6 address NACK", gotErr, 1);
    end
    if (stAt > 0)
      chk(lastStretchLow == STRK + 1, "R5 stretched low held", lastStretchLow, STRK + 1);
  endtask

  task automatic runWrite(input int n, input int nk, input bit good);
    clearModel();
    addr = good ? TGT : TGT ^ 7'h05;
    nWr = n; nackAt = nk; stretchAt = -1;
    for (int i = 0; i < 4; i++) wrData[i] = 8'(8'hC5 ^ (i * 8'd29) ^ n);
    cmdByte = wrData[0]; cmdLast = (n == 1);
    pulseReq(1'b0, 1'b1);
    waitDone();
    chk(addrSeen == {addr, 1'b0}, "R3 write address frame", addrSeen, {addr, 1'b0});
    chk(startCnt == 1 && stopCnt == 1, "R2 one Start one Stop", startCnt * 10 + stopCnt, 11);
    chk(timErr == 0, "R13 phase lengths", timErr, 0);
    if (!good) chk(gotErr && takes == 0, "R6 write address NACK", takes, 0);
    else begin
      automatic int expB = (nk != 0) ? nk : n;
      automatic int bad = 0;
      for (int i = 0; i < expB; i++) if (wrSeen[i] != wrData[i]) bad++;
      chk(wrCnt == expB && bad == 0, (nk != 0) ? "R10 bytes before NACK" : "R9 bytes sent",
          wrCnt * 100 + bad, expB * 100);
      chk(takes == expB, "R9 take pulses", takes, expB);
      chk(gotErr == (nk != 0), (nk != 0) ? "R10 error flag" : "R9 no error", gotErr, nk != 0);
    end
    nackAt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!sclOe && !sdaOe && !busy && !done, "R1 reset state", {sclOe, sdaOe, busy, done}, 0);
    for (int h = 2; h <= 3; h++) begin
      hp = 16'(h);
      for (int s = 0; s <= 5; s++) runRead(8'(s), 1'b1, (s == 3) ? 14 : -1);
      runRead(8'd2, 1'b1, 5);
      runRead(8'd4, 1'b0, -1);
      for (int n = 1; n <= 3; n++) runWrite(n, 0, 1'b1);
      runWrite(3, 2, 1'b1);
      runWrite(2, 0, 1'b0);
    end
    // R12: simultaneous requests, read wins; a request during busy is dropped
    hp = 16'd2;
    clearModel();
    addr = TGT; expN = 2; rdBytes[0] = 8'd2; rdBytes[1] = 8'h9A;
    pulseReq(1'b1, 1'b1);
    repeat (20) @(negedge clk);
    writeReq = 1'b1;
    @(negedge clk);
    writeReq = 1'b0;
    waitDone();
    repeat (40) @(negedge clk);
    chk(addrSeen[0] == 1'b1, "R12 read priority", addrSeen[0], 1);
    chk(startCnt == 1 && !busy, "R12 busy request ignored", startCnt, 1);
    chk(rxIdx == 2 && rxErr == 0, "R12 read intact", rxIdx, 2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule